// File: doc/BRIEF.md
# Credit-Based Flow-Controlled Link

This block carries data words from a producer to a consumer across a wire that takes several cycles to cross. The sending half and the receiving half sit at opposite ends. Between them run two register pipelines: a forward one for data and a reverse one for credits. Because a ready signal cannot cross the distance in the same cycle, the sender keeps a count of free receive-buffer slots. The count drops by one for every word launched and rises by one for every credit the receiver sends back after the consumer takes a word.

The one-way latency `LAT` (N) and the word width are parameters. In each direction the path holds N registers. Forward, these are N-1 pipeline stages plus the receive-buffer write. In reverse, they are N-1 pipeline stages plus the credit counter. The receive buffer holds 2*N words. That is the whole round trip, so a consumer that always takes words sees one word per cycle. After a full stall, the consumer drains the buffered words with no gap while the flow starts again. Both ends use valid/ready handshakes. A transfer happens on a rising clock edge when valid and ready are both high.

Top module: `credit_link`

## Requirements
- R1: After reset the receive buffer is empty (`dst_valid` low), the sender holds 2*N credits, and `src_ready` is high.
- R2: The sender accepts a word only while it holds a credit. With the consumer stopped and the producer always valid, exactly 2*N words are accepted and `src_ready` then stays low.
- R3: A word accepted at clock edge k is offered on `dst_valid`/`dst_data` so that it can be taken at edge k+N at the earliest.
- R4: A word dequeued at edge p returns its credit such that `src_ready` is high after edge p+N-1 and a new word can be launched at edge p+N.
- R5: When the producer is always valid and the consumer always ready, once the pipeline has filled the link moves one word per cycle at both ends and `src_ready` never drops.
- R6: After a full stall, a consumer that becomes always ready takes a word on every cycle with no gap. It works first from the 2*N buffered words and then from the refilled flow.
- R7: Words leave in the order they were accepted, with unchanged data, none lost and none duplicated, under any mix of valid and ready.
- R8: No word is ever written into a full receive buffer.
- R9: The credit count never exceeds 2*N. A launch and a returned credit in the same cycle leave it unchanged, so after any traffic the full 2*N credits return once the link is idle.
- R10: While `dst_valid` is high and `dst_ready` is low, `dst_valid` stays high and `dst_data` holds its value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Producer offers a word |
| src_ready | output | 1 | Sender holds at least one credit |
| src_data | input | DATA_W | Word offered by the producer |
| dst_valid | output | 1 | Receive buffer holds a word |
| dst_ready | input | 1 | Consumer takes the offered word |
| dst_data | output | DATA_W | Oldest word in the receive buffer |

## Verification
On every cycle the assertions check four things. Credits, buffered words, words in flight and credits in flight always add up to 2*N. No write reaches a full buffer. The credit count stays within range. An offered word holds steady while it waits. Only the bench scenarios can show the cycle counts of forward and credit latency, the exact number of words a stall lets through, gap-free draining and full-rate streaming. The bench's ordered scoreboard checks data order and integrity under random traffic.

// File: rtl/credit_link_pkg.sv
`timescale 1ns/1ps
package credit_link_pkg;
  // Bits needed to hold any value from 0 to max_val inclusive.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/cl_delay_line.sv
`timescale 1ns/1ps
// Multi-cycle wire model: STAGES registers carrying a valid bit and a payload.
// STAGES == 0 degenerates to a plain connection.
module cl_delay_line #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  input  logic [W-1:0]                           in_data,
  output logic                                   out_valid,
  output logic [W-1:0]                           out_data,
  output logic [((STAGES > 0) ? STAGES : 1)-1:0] stage_valid
);

  generate
    if (STAGES == 0) begin : g_wire
      assign out_valid   = in_valid;
      assign out_data    = in_data;
      assign stage_valid = '0;
    end else begin : g_regs
      logic [STAGES-1:0] vld_q;
      logic [STAGES-1:0] vld_d;
      logic [W-1:0]      dat_q [STAGES];
      logic [W-1:0]      dat_d [STAGES];

      always_comb begin
        vld_d[0] = in_valid;
        dat_d[0] = in_data;
        for (int i = 1; i < STAGES; i++) begin
          vld_d[i] = vld_q[i-1];
          dat_d[i] = dat_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= '0;
        end else begin
          vld_q <= vld_d;
        end
      end

      // Payload flops carry no reset; each loads only when its valid does.
      for (genvar s = 0; s < STAGES; s++) begin : g_dat
        always_ff @(posedge clk) begin
          if (vld_d[s]) begin
            dat_q[s] <= dat_d[s];
          end
        end
      end

      assign out_valid   = vld_q[STAGES-1];
      assign out_data    = dat_q[STAGES-1];
      assign stage_valid = vld_q;
    end
  endgenerate

endmodule

// File: rtl/cl_sender.sv
`timescale 1ns/1ps
// Send-side control: credit counter gating the producer handshake.
module cl_sender #(
  parameter int DEPTH = 6,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic          credit_ret,
  output logic          launch,
  output logic [CW-1:0] credits
);

  logic [CW-1:0] credits_q;
  logic [CW-1:0] credits_d;
  logic          credits_en;

  assign src_ready = (credits_q != '0);
  assign launch    = src_valid & src_ready;
  assign credits   = credits_q;

  always_comb begin
    credits_en = launch ^ credit_ret;
    credits_d  = credits_q;
    if (launch && !credit_ret) begin
      credits_d = credits_q - 1'b1;
    end else if (credit_ret && !launch) begin
      credits_d = credits_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credits_q <= CW'(DEPTH);
    end else if (credits_en) begin
      credits_q <= credits_d;
    end
  end

  // R9
  credit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(credits_q) <= DEPTH)
    else $error("credit count above buffer depth");

endmodule

// File: rtl/cl_rx_buffer.sv
`timescale 1ns/1ps
// Receive-side buffer: circular store of DEPTH words, one-credit-per-pop.
module cl_rx_buffer #(
  parameter int W     = 16,
  parameter int DEPTH = 6,
  parameter int CW    = 3,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  output logic          dst_valid,
  input  logic          dst_ready,
  output logic [W-1:0]  dst_data,
  output logic          pop,
  output logic [CW-1:0] occupancy
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q,  count_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign dst_valid = (count_q != '0);
  assign dst_data  = mem[rd_ptr_q];
  assign pop       = dst_valid & dst_ready;
  assign occupancy = count_q;

  always_comb begin
    wr_ptr_d = wr_valid ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop      ? bump(rd_ptr_q) : rd_ptr_q;
    count_d  = count_q;
    if (wr_valid && !pop) begin
      count_d = count_q + 1'b1;
    end else if (pop && !wr_valid) begin
      count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_valid)         wr_ptr_q <= wr_ptr_d;
      if (pop)              rd_ptr_q <= rd_ptr_d;
      if (wr_valid ^ pop)   count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_valid) begin
      mem[wr_ptr_q] <= wr_data;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (int'(count_q) < DEPTH))
    else $error("write into full receive buffer");

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)))
    else $error("offered word changed while waiting");

endmodule

// File: rtl/credit_link.sv
`timescale 1ns/1ps
// Top: sender, forward data wire, receive buffer, reverse credit wire.
module credit_link
  import credit_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [DATA_W-1:0] dst_data
);

  localparam int DEPTH = 2 * LAT;
  localparam int CW    = cnt_width(DEPTH);
  localparam int PW    = $clog2(DEPTH);
  localparam int HOPS  = LAT - 1;
  localparam int VW    = (HOPS > 0) ? HOPS : 1;

  logic              launch;
  logic [CW-1:0]     credits;
  logic              fwd_valid;
  logic [DATA_W-1:0] fwd_data;
  logic [VW-1:0]     fwd_stage_v;
  logic              pop;
  logic [CW-1:0]     occupancy;
  logic              crd_valid;
  logic [0:0]        crd_token;
  logic [VW-1:0]     crd_stage_v;
  logic              credit_ret;

  cl_sender #(.DEPTH(DEPTH), .CW(CW)) u_sender (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_valid  (src_valid),
    .src_ready  (src_ready),
    .credit_ret (credit_ret),
    .launch     (launch),
    .credits    (credits)
  );

  cl_delay_line #(.W(DATA_W), .STAGES(HOPS)) u_fwd_wire (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (launch),
    .in_data     (src_data),
    .out_valid   (fwd_valid),
    .out_data    (fwd_data),
    .stage_valid (fwd_stage_v)
  );

  cl_rx_buffer #(.W(DATA_W), .DEPTH(DEPTH), .CW(CW), .PW(PW)) u_rx_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (fwd_valid),
    .wr_data   (fwd_data),
    .dst_valid (dst_valid),
    .dst_ready (dst_ready),
    .dst_data  (dst_data),
    .pop       (pop),
    .occupancy (occupancy)
  );

  // Reverse wire carries a one-bit token; a credit is a valid token of 1.
  cl_delay_line #(.W(1), .STAGES(HOPS)) u_crd_wire (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (pop),
    .in_data     (1'b1),
    .out_valid   (crd_valid),
    .out_data    (crd_token),
    .stage_valid (crd_stage_v)
  );

  assign credit_ret = crd_valid & crd_token[0];

  // R2: every slot is either a credit, a buffered word, a word in flight
  // or a credit in flight; nothing is created or lost along the loop.
  credit_conservation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(credits) + int'(occupancy) + $countones(fwd_stage_v)
       + $countones(crd_stage_v)) == DEPTH)
    else $error("credit loop does not add up to buffer depth");

endmodule

// File: tb/credit_link_bench.sv
`timescale 1ns/1ps
module credit_link_bench;

  localparam int LAT   = 3;
  localparam int DW    = 16;
  localparam int DEPTH = 2 * LAT;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          src_valid;
  logic          src_ready;
  logic [DW-1:0] src_data;
  logic          dst_valid;
  logic          dst_ready;
  logic [DW-1:0] dst_data;

  int errors = 0;
  int checks = 0;
  int src_mode = 0;   // 0 idle, 1 always valid, 2 random, 3 one word
  int dst_mode = 0;   // 0 stopped, 1 always ready, 2 random, 3 one pop
  int acc_cnt = 0;
  int pop_cnt = 0;
  bit done = 0;
  logic [DW-1:0] next_word = 16'h0101;
  logic [DW-1:0] word_q [$];

  always #10 clk = ~clk;   // 50 MHz

  credit_link #(.DATA_W(DW), .LAT(LAT)) u_credit_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_data  (src_data),
    .dst_valid (dst_valid),
    .dst_ready (dst_ready),
    .dst_data  (dst_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver and scoreboard monitor: drive at the falling edge, then observe
  // the handshakes that the next rising edge will perform.
  always @(negedge clk) begin
    src_valid = (src_mode == 1) || (src_mode == 3) ||
                ((src_mode == 2) && ($urandom_range(0, 1) == 1));
    src_data  = next_word;
    dst_ready = (dst_mode == 1) || (dst_mode == 3) ||
                ((dst_mode == 2) && ($urandom_range(0, 2) != 0));
    #1;
    if (rst_n && src_valid && src_ready) begin
      word_q.push_back(src_data);
      next_word = next_word * 16'd5 + 16'h1357;
      acc_cnt++;
      if (src_mode == 3) src_mode = 0;
    end
    if (rst_n && dst_valid && dst_ready) begin
      pop_cnt++;
      if (word_q.size() == 0) begin
        chk(1'b0, "R7", "word delivered that was never sent", dst_data, 0);
      end else begin
        logic [DW-1:0] exp_w;
        exp_w = word_q.pop_front();
        // R7: order and integrity
        chk(dst_data == exp_w, "R7", "delivered word", dst_data, exp_w);
      end
      if (dst_mode == 3) dst_mode = 0;
    end
  end

  task automatic set_modes(input int s, input int d);
    @(posedge clk);
    #1;
    src_mode = s;
    dst_mode = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int base;
    int n;
    int gaps;
    int moves_in;
    int moves_out;
    logic [DW-1:0] held;

    rst_n = 1'b0;
    src_valid = 1'b0;
    dst_ready = 1'b0;
    src_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    // R1: reset state
    chk(src_ready == 1'b1, "R1", "src_ready after reset", src_ready, 1);
    chk(dst_valid == 1'b0, "R1", "dst_valid after reset", dst_valid, 0);

    // R3: forward latency of a single word into an idle link
    set_modes(3, 1);
    base = acc_cnt;
    n = 0;
    while (acc_cnt == base && n < 50) begin @(negedge clk); #5; n++; end
    n = 0;
    do begin @(negedge clk); #5; n++; end while (!dst_valid && n < 50);
    chk(n == LAT, "R3", "edges from launch to first take", n, LAT);
    repeat (10) @(negedge clk);

    // R2 and R8: consumer stopped, producer always valid
    base = acc_cnt;
    set_modes(1, 0);
    repeat (4 * LAT + 10) @(negedge clk);
    #5;
    chk(acc_cnt - base == DEPTH, "R2", "words accepted during stall", acc_cnt - base, DEPTH);
    chk(src_ready == 1'b0, "R2", "src_ready once credits are spent", src_ready, 0);
    chk(word_q.size() == DEPTH, "R8", "words held without loss at full", word_q.size(), DEPTH);
    // R10: offered word held while not taken
    chk(dst_valid == 1'b1, "R10", "dst_valid during stall", dst_valid, 1);
    held = dst_data;
    repeat (3) @(negedge clk);
    #5;
    chk(dst_data == held, "R10", "dst_data held during stall", dst_data, held);

    // R4: credit return latency after one pop
    set_modes(1, 3);
    base = pop_cnt;
    n = 0;
    while (pop_cnt == base && n < 50) begin @(negedge clk); #5; n++; end
    n = 0;
    do begin @(negedge clk); #5; n++; end while (!src_ready && n < 50);
    chk(n == LAT, "R4", "edges from pop to src_ready", n, LAT);
    repeat (4 * LAT + 4) @(negedge clk);
    #5;
    chk(src_ready == 1'b0, "R2", "link full again before release", src_ready, 0);

    // R6: drain after full stall, no gap while the flow restarts
    set_modes(1, 1);
    gaps = 0;
    repeat (4 * DEPTH) begin
      @(negedge clk); #5;
      if (!dst_valid) gaps++;
    end
    chk(gaps == 0, "R6", "empty cycles while draining", gaps, 0);

    // R5: steady full-rate streaming
    moves_in = 0;
    moves_out = 0;
    repeat (40) begin
      @(negedge clk); #5;
      if (src_valid && src_ready) moves_in++;
      if (dst_valid && dst_ready) moves_out++;
    end
    chk(moves_in == 40, "R5", "words accepted in 40 cycles", moves_in, 40);
    chk(moves_out == 40, "R5", "words delivered in 40 cycles", moves_out, 40);

    // R7: random valid/ready mix, then drain
    set_modes(2, 2);
    repeat (3000) @(negedge clk);
    set_modes(0, 1);
    repeat (8 * LAT + 10) @(negedge clk);
    #5;
    chk(word_q.size() == 0, "R7", "words left undelivered", word_q.size(), 0);
    chk(acc_cnt == pop_cnt, "R7", "delivered count", pop_cnt, acc_cnt);

    // R9: full credit count restored after random traffic
    base = acc_cnt;
    set_modes(1, 0);
    repeat (4 * LAT + 10) @(negedge clk);
    #5;
    chk(acc_cnt - base == DEPTH, "R9", "credits after random traffic", acc_cnt - base, DEPTH);
    set_modes(0, 1);
    repeat (4 * LAT + 10) @(negedge clk);
    #5;
    chk(word_q.size() == 0, "R7", "words left after final drain", word_q.size(), 0);
    chk(dst_valid == 1'b0, "R7", "buffer empty after final drain", dst_valid, 0);

    finish_run();
  end

endmodule